// File: doc/BRIEF.md
# Capacitor Bank Step Controller

This block regulates a lagging power-factor angle by switching shunt capacitor sections in or out of a bank. Each time a new phase-difference measurement arrives, the block compares it with two limits. The measurement is a count of samples, marked by a one-cycle valid strobe. A measurement above the upper limit means the load is too inductive, so one more section is connected. A measurement below the lower limit means the load is over-corrected, so one section is released. A measurement between the limits, or equal to either one, leaves the bank as it is.

Sections are always engaged as a thermometer code. Section k comes on only after sections 0 to k-1 are on, and sections come off from the top down. Switching saturates at a full bank and at an empty bank. After every real switch, the block ignores a programmable number of valid measurements before it decides again. This hold-off stops chatter while the line settles. The two limits and the hold-off length are static configuration inputs, in the same count units as the measurement. Reset is synchronous. It empties the bank and cancels any pending hold-off.

Top module: `cap_step_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, `sect_en` becomes all zeros and any pending hold-off is cancelled. The first valid measurement after reset is therefore decided at once.
- R2: A valid measurement with `meas_phase` > `thr_hi` turns on the lowest section that is off. This happens when no hold-off is pending and the bank is not full, and `sect_en` shows the change on the clock edge that samples the strobe.
- R3: A valid measurement with `meas_phase` < `thr_lo` turns off the highest section that is on. This happens when no hold-off is pending and the bank is not empty.
- R4: A valid measurement with `thr_lo` <= `meas_phase` <= `thr_hi` leaves `sect_en` unchanged. Equality with either limit counts as inside the band.
- R5: `sect_en` is always a thermometer code: bit 0 is the first section, and the bits that are set form a contiguous run starting at bit 0. At most one bit changes per clock.
- R6: A request to add a section when all SECTIONS bits are set leaves the bank full. A request to remove a section when no bit is set leaves the bank empty.
- R7: After a measurement that switches a section, the next `holdoff_n` valid measurements change nothing, whatever their values. The measurement after them is decided normally. With `holdoff_n` = 0, every valid measurement is decided.
- R8: A request blocked by saturation does not start a hold-off. The next valid measurement is decided normally.
- R9: `sect_en` does not change in a cycle where `meas_valid` is low, whatever the value of `meas_phase`.
- R10: If `thr_lo` > `thr_hi` and the measurement is both above `thr_hi` and below `thr_lo`, adding a section takes priority over removing one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| meas_valid | input | 1 | One-cycle strobe marking a new measurement |
| meas_phase | input | PH_W (4) | Measured phase difference in sample counts |
| thr_hi | input | PH_W (4) | Upper angle limit; above it a section is added |
| thr_lo | input | PH_W (4) | Lower angle limit; below it a section is removed |
| holdoff_n | input | HOLD_W (4) | Number of valid measurements ignored after a switch |
| sect_en | output | SECTIONS (9) | Section enables, thermometer coded, bit 0 first |

## Verification
An internal fault shows up first in `sect_en`. A lost or stale hold-off count shows as a step one measurement too early or too late, and the effect appears on the edge that samples that strobe. A corrupted bank register breaks the thermometer shape or jumps by more than one section within one cycle. A saturation fault shows as a wrap to empty, or as a blocked request that still starts a hold-off, which delays the next step by `holdoff_n` measurements. Because every decision is visible one edge after its strobe, each measurement is paired with one expected bank value.

// File: rtl/cap_step_pkg.sv
package cap_step_pkg;

    // Outcome of comparing one measurement with the band limits
    typedef enum logic [1:0] {
        STEP_KEEP = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_e;

endpackage

// File: rtl/band_judge.sv
module band_judge
    import cap_step_pkg::*;
#(
    parameter int PH_W = 4
) (
    input  logic [PH_W-1:0] phase,
    input  logic [PH_W-1:0] lim_hi,
    input  logic [PH_W-1:0] lim_lo,
    output step_e           step
);

    logic above_w;
    logic below_w;

    assign above_w = (phase > lim_hi);
    assign below_w = (phase < lim_lo);

    // Adding a section wins when inverted limits make both conditions true
    always_comb begin
        if (above_w) begin
            step = STEP_UP;
        end else if (below_w) begin
            step = STEP_DOWN;
        end else begin
            step = STEP_KEEP;
        end
    end

endmodule

// File: rtl/holdoff_gate.sv
module holdoff_gate #(
    parameter int HOLD_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              meas_valid,
    input  logic              switched,
    input  logic [HOLD_W-1:0] holdoff_n,
    output logic              busy
);

    typedef struct packed {
        logic [HOLD_W-1:0] left;
    } hold_t;

    hold_t hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (switched) begin
            hold_d.left = holdoff_n;
        end else if (meas_valid && (hold_q.left != '0)) begin
            hold_d.left = hold_q.left - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    assign busy = (hold_q.left != '0);

    // R7
    switch_only_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        switched |-> !busy);

    // R7
    hold_counts_down_chk: assert property (@(posedge clk) disable iff (rst)
        (meas_valid && busy && !switched) |=> (hold_q.left == $past(hold_q.left) - 1'b1));

endmodule

// File: rtl/therm_bank.sv
module therm_bank #(
    parameter int SECTIONS = 9
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                add_one,
    input  logic                drop_one,
    output logic [SECTIONS-1:0] sect_en,
    output logic                full,
    output logic                empty
);

    localparam int EXT_W = SECTIONS + 1;

    typedef struct packed {
        logic [SECTIONS-1:0] bank;
    } bank_t;

    bank_t bank_d, bank_q;

    // Shift in a one at the bottom to add, shift out the top one to drop
    always_comb begin
        bank_d = bank_q;
        if (add_one && !bank_q.bank[SECTIONS-1]) begin
            bank_d.bank = {bank_q.bank[SECTIONS-2:0], 1'b1};
        end else if (drop_one && bank_q.bank[0]) begin
            bank_d.bank = {1'b0, bank_q.bank[SECTIONS-1:1]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign sect_en = bank_q.bank;
    assign full    = bank_q.bank[SECTIONS-1];
    assign empty   = !bank_q.bank[0];

    logic [EXT_W-1:0] ext_w;
    assign ext_w = {1'b0, bank_q.bank};

    // R5
    thermometer_shape_chk: assert property (@(posedge clk) disable iff (rst)
        ((ext_w + 1'b1) & ext_w) == '0);

    // R5
    single_step_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(sect_en ^ $past(sect_en)) <= 1);

    // R6
    no_wrap_full_chk: assert property (@(posedge clk) disable iff (rst)
        (full && !drop_one) |=> full);

    // R6
    no_wrap_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (empty && !add_one) |=> empty);

endmodule

// File: rtl/cap_step_ctrl.sv
module cap_step_ctrl
    import cap_step_pkg::*;
#(
    parameter int SECTIONS = 9,
    parameter int PH_W     = 4,
    parameter int HOLD_W   = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                meas_valid,
    input  logic [PH_W-1:0]     meas_phase,
    input  logic [PH_W-1:0]     thr_hi,
    input  logic [PH_W-1:0]     thr_lo,
    input  logic [HOLD_W-1:0]   holdoff_n,
    output logic [SECTIONS-1:0] sect_en
);

    step_e step_w;
    logic  busy_w;
    logic  full_w;
    logic  empty_w;
    logic  decide_w;
    logic  add_w;
    logic  drop_w;
    logic  switched_w;

    band_judge #(
        .PH_W (PH_W)
    ) u_judge (
        .phase  (meas_phase),
        .lim_hi (thr_hi),
        .lim_lo (thr_lo),
        .step   (step_w)
    );

    // A decision is taken only on a valid measurement outside hold-off
    always_comb begin
        decide_w   = meas_valid && !busy_w;
        add_w      = decide_w && (step_w == STEP_UP)   && !full_w;
        drop_w     = decide_w && (step_w == STEP_DOWN) && !empty_w;
        switched_w = add_w || drop_w;
    end

    holdoff_gate #(
        .HOLD_W (HOLD_W)
    ) u_hold (
        .clk        (clk),
        .rst        (rst),
        .meas_valid (meas_valid),
        .switched   (switched_w),
        .holdoff_n  (holdoff_n),
        .busy       (busy_w)
    );

    therm_bank #(
        .SECTIONS (SECTIONS)
    ) u_bank (
        .clk      (clk),
        .rst      (rst),
        .add_one  (add_w),
        .drop_one (drop_w),
        .sect_en  (sect_en),
        .full     (full_w),
        .empty    (empty_w)
    );

    // R9
    idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !meas_valid |=> $stable(sect_en));

    // R7
    holdoff_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (meas_valid && busy_w) |=> $stable(sect_en));

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (sect_en == '0));

    // R2
    step_up_chk: assert property (@(posedge clk) disable iff (rst)
        add_w |=> ($countones(sect_en) == $countones($past(sect_en)) + 1));

    // R3
    step_down_chk: assert property (@(posedge clk) disable iff (rst)
        drop_w |=> ($countones(sect_en) + 1 == $countones($past(sect_en))));

endmodule

// File: tb/sim_cap_step_ctrl.sv
module sim_cap_step_ctrl;

    localparam int SECTIONS = 9;
    localparam int PH_W     = 4;
    localparam int HOLD_W   = 4;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                meas_valid = 1'b0;
    logic [PH_W-1:0]     meas_phase = '0;
    logic [PH_W-1:0]     thr_hi = 4'd9;
    logic [PH_W-1:0]     thr_lo = 4'd7;
    logic [HOLD_W-1:0]   holdoff_n = '0;
    logic [SECTIONS-1:0] sect_en;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    // reference model state
    int m_cnt  = 0;
    int m_hold = 0;

    logic [SECTIONS-1:0] exp_q[$];
    string               tag_q[$];

    always #2.5 clk = ~clk;

    cap_step_ctrl #(
        .SECTIONS (SECTIONS),
        .PH_W     (PH_W),
        .HOLD_W   (HOLD_W)
    ) u0 (
        .clk        (clk),
        .rst        (rst),
        .meas_valid (meas_valid),
        .meas_phase (meas_phase),
        .thr_hi     (thr_hi),
        .thr_lo     (thr_lo),
        .holdoff_n  (holdoff_n),
        .sect_en    (sect_en)
    );

    function automatic logic [SECTIONS-1:0] therm(input int n);
        logic [SECTIONS-1:0] v = '0;
        for (int i = 0; i < SECTIONS; i++) begin
            if (i < n) v[i] = 1'b1;
        end
        return v;
    endfunction

    task automatic check(input string req, input logic [SECTIONS-1:0] act,
                         input logic [SECTIONS-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Driver: one valid measurement, expected bank value pushed after the edge
    task automatic send(input int ph, input string req);
        logic [SECTIONS-1:0] e;
        @(negedge clk);
        meas_phase = PH_W'(ph);
        meas_valid = 1'b1;
        if (m_hold > 0) begin
            m_hold--;
        end else if (ph > int'(thr_hi)) begin
            if (m_cnt < SECTIONS) begin
                m_cnt++;
                m_hold = int'(holdoff_n);
            end
        end else if (ph < int'(thr_lo)) begin
            if (m_cnt > 0) begin
                m_cnt--;
                m_hold = int'(holdoff_n);
            end
        end
        e = therm(m_cnt);
        @(posedge clk);
        #1;
        exp_q.push_back(e);
        tag_q.push_back(req);
        @(negedge clk);
        meas_valid = 1'b0;
    endtask

    task automatic do_reset(input string req);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_cnt  = 0;
        m_hold = 0;
        check(req, sect_en, '0);
    endtask

    // Monitor: compares each expected item once the design has produced it
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (exp_q.size() > 0) begin
                check(tag_q.pop_front(), sect_en, exp_q.pop_front());
            end
        end
    end

    initial begin
        do_reset("R1 reset clears bank");
        send(8, "R4 inside band");
        send(7, "R4 equal lower limit");
        send(9, "R4 equal upper limit");
        send(12, "R2 add first section");
        send(12, "R2 add second section");
        send(3, "R3 remove section");
        send(3, "R3 remove last section");
        send(3, "R6 empty saturates");
        for (int i = 0; i < SECTIONS; i++) send(15, "R2 fill bank");
        send(15, "R6 full saturates");

        // R9: no strobe, phase far outside band
        @(negedge clk);
        meas_phase = 4'd0;
        repeat (5) @(negedge clk);
        check("R9 no change without valid", sect_en, therm(m_cnt));

        holdoff_n = 4'd3;
        send(15, "R8 blocked add at full");
        send(0, "R8 no hold-off after blocked add");
        send(0, "R7 hold-off 1");
        send(14, "R7 hold-off 2");
        send(0, "R7 hold-off 3");
        send(0, "R7 decide after hold-off");
        send(8, "R7 hold-off burn");
        send(8, "R7 hold-off burn");
        send(8, "R7 hold-off burn");
        thr_hi = 4'd5;
        thr_lo = 4'd10;
        send(7, "R10 add wins with inverted limits");
        thr_hi = 4'd9;
        thr_lo = 4'd7;
        send(0, "R7 in hold-off after R10 step");

        do_reset("R1 reset mid-run");
        send(12, "R1 hold-off cancelled by reset");
        send(3, "R7 hold-off after reset step");
        repeat (4) @(negedge clk);
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule